// File: doc/BRIEF.md
# Buffered Synchronous Serial Receiver

This block receives clocked serial data. One bit enters from the serial data input on each rising serial clock edge, most significant bit first. A word is either 4 or 8 bits long. Each finished word is written into the next slot of a small word buffer. When the programmed number of words has arrived, a one-cycle interrupt pulse tells the processor to read the buffer.

The serial clock comes from one of two sources. The first is an internal divider, which also drives `sck_out`. The second is an external clock pin, which passes through a two-flop synchroniser before its edges are detected. The two sources handle an unread buffer differently:
- With the internal clock, the block holds the finished word and stops the serial clock (an automatic wait) until the processor reads.
- With the external clock, the finished word is dropped and reception ends.

Reception can be stopped in two ways:
- Lowering the start level is a graceful stop. It finishes and stores the word in progress.
- An inhibit pulse is an immediate abort. It throws away the partial word.

Top module: `bsync_rx`

## Requirements
- R1: Bits are sampled on the rising serial clock edge, most significant bit first. With `word8`=1 a word is 8 bits. With `word8`=0 a word is 4 bits, stored in bits [3:0] of its slot with bits [7:4] zero.
- R2: After a session start, the k-th finished word (k counted from 0) is written to buffer slot k. Any slot is visible on `rd_data` when `rd_addr` selects it.
- R3: A `cnt_val` value v sets the word count to v+1. When the (v+1)-th word is stored, `irq` is high for exactly one clock cycle, and the next word goes to slot 0 again.
- R4: Internal clock only: if a word finishes while a full buffer is still unread, `sck_out` stays low and the word is held. A `rd_en` pulse to any slot address, used or not, releases the wait and stores the held word in slot 0.
- R5: If `rd_en` is pulsed between the interrupt and the completion of the next word, no wait occurs. The next word is stored normally.
- R6: External clock only: if a word finishes while a full buffer is still unread, that word is discarded and `busy` drops. Later external clock edges store nothing and raise no interrupt.
- R7: Lowering `start_en` during a word keeps `busy` high until that word's last bit. The word is then stored and `busy` drops.
- R8: An `inhibit` pulse forces `busy` low at the next clock edge. The partial word is discarded and the buffer is left unchanged.
- R9: A change of `word8` clears every buffer slot to zero.
- R10: A `cnt_wr` pulse is accepted only in two cases: while `busy` is 0, or, with the internal clock, during an automatic wait. With the external clock, a write while `busy` is 1 is ignored.
- R11: `busy` goes high on the clock edge after a rising edge of `start_en`. It resets to 0, as do `irq`, `sck_out` and all buffer slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_en | input | 1 | Start level: rising edge begins a session, falling edge requests a graceful stop |
| inhibit | input | 1 | Immediate abort pulse |
| word8 | input | 1 | Word length select: 1 = 8 bits, 0 = 4 bits |
| ext_sel | input | 1 | Clock source: 1 = external pin, 0 = internal divider |
| ext_sck | input | 1 | External serial clock (asynchronous) |
| ser_in | input | 1 | Serial data input |
| cnt_wr | input | 1 | Word-count write strobe |
| cnt_val | input | AW | Word count minus one |
| rd_en | input | 1 | Processor read strobe for the buffer |
| rd_addr | input | AW | Buffer slot select |
| rd_data | output | 8 | Contents of the selected slot |
| sck_out | output | 1 | Internally generated serial clock |
| busy | output | 1 | Reception in progress |
| irq | output | 1 | Buffer-full pulse |

## Verification
The hardest state to reach is the automatic wait. To get there, the buffer must already be full and unread, and a further word must finish on the internally generated clock. The bench times every data bit from the falling edges of `sck_out`, so it can stream word-count-plus-one words back to back. It then watches `sck_out` stay low while nothing is read. During that wait it rewrites the word count, and then releases the wait by reading a slot that holds no data. The number of interrupts after the release shows that the rewrite took effect.

// File: rtl/bsrx_pkg.sv
`timescale 1ns/1ps
package bsrx_pkg;
    localparam int WORD_W = 8;
    localparam int HALF_W = WORD_W / 2;
    localparam int BIT_W  = $clog2(WORD_W);
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bsrx_sck.sv
`timescale 1ns/1ps
module bsrx_sck #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_sel,
    input  logic ext_sck,
    output logic sck_out,
    output logic rise
);
    localparam int CW = $clog2(DIV_HALF + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic          sck;
        logic          rise;
        logic [CW-1:0] cnt;
    } sck_state_t;

    sck_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], ext_sck};
        s_d.prev = s_q.sync[1];
        s_d.rise = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.sck = 1'b0;
        end else if (ext_sel) begin
            s_d.cnt  = '0;
            s_d.sck  = 1'b0;
            s_d.rise = s_q.sync[1] & ~s_q.prev;
        end else if (s_q.cnt == CW'(DIV_HALF - 1)) begin
            s_d.cnt  = '0;
            s_d.sck  = ~s_q.sck;
            s_d.rise = ~s_q.sck;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_out = s_q.sck;
    assign rise    = s_q.rise;

    // R4: a stalled engine drives the serial clock low
    p_stall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck_out);
    // R1: no sample strobe while the engine is stopped
    p_no_rise_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rise);
endmodule

// File: rtl/bsrx_buf.sv
`timescale 1ns/1ps
module bsrx_buf
    import bsrx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t slot_d [DEPTH];
    word_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (clr)                         slot_d[g] = '0;
            else if (we && widx == AW'(g))   slot_d[g] = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
        // R9: clearing empties each slot
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (slot_q[g] == '0));
        // R2: a write lands in the addressed slot
        p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !clr && widx == AW'(g)) |=> (slot_q[g] == $past(wdata)));
    end

    assign rdata = (32'(raddr) < DEPTH) ? slot_q[raddr] : '0;
endmodule

// File: rtl/bsync_rx.sv
`timescale 1ns/1ps
module bsync_rx
    import bsrx_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int DEPTH    = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_en,
    input  logic          inhibit,
    input  logic          word8,
    input  logic          ext_sel,
    input  logic          ext_sck,
    input  logic          ser_in,
    input  logic          cnt_wr,
    input  logic [AW-1:0] cnt_val,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          sck_out,
    output logic          busy,
    output logic          irq
);
    typedef struct packed {
        logic             busy;
        logic             stop;
        logic             hold;
        logic             full;
        logic             irq;
        logic             start_q;
        logic             mode8;
        logic [AW-1:0]    wr_idx;
        logic [AW-1:0]    cnt;
        logic [BIT_W-1:0] bit_cnt;
        word_t            shreg;
        word_t            pend;
    } rx_state_t;

    rx_state_t s_d, s_q;

    logic          rise;
    logic          run;
    logic          buf_clr;
    logic          store_req;
    word_t         store_word;
    word_t         word_now;
    word_t         rd_word;
    logic [BIT_W-1:0] last_bit;

    assign run = s_q.busy & ~s_q.hold;

    bsrx_sck #(.DIV_HALF(DIV_HALF)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ext_sel (ext_sel),
        .ext_sck (ext_sck),
        .sck_out (sck_out),
        .rise    (rise)
    );

    always_comb begin
        last_bit = s_q.mode8 ? BIT_W'(WORD_W - 1) : BIT_W'(HALF_W - 1);
        if (s_q.mode8) word_now = {s_q.shreg[WORD_W-2:0], ser_in};
        else           word_now = word_t'({s_q.shreg[HALF_W-2:0], ser_in});
    end

    always_comb begin
        s_d        = s_q;
        s_d.irq    = 1'b0;
        s_d.start_q = start_en;
        buf_clr    = 1'b0;
        store_req  = 1'b0;
        store_word = word_now;

        if (rd_en) s_d.full = 1'b0;

        if (start_en && !s_q.start_q && !s_q.busy) begin
            s_d.busy    = 1'b1;
            s_d.stop    = 1'b0;
            s_d.hold    = 1'b0;
            s_d.full    = 1'b0;
            s_d.wr_idx  = '0;
            s_d.bit_cnt = '0;
        end else if (s_q.busy) begin
            if (!start_en && s_q.start_q) begin
                if (s_q.bit_cnt == '0 && !s_q.hold) s_d.busy = 1'b0;
                else                               s_d.stop = 1'b1;
            end
            if (s_q.hold) begin
                if (rd_en) begin
                    store_req  = 1'b1;
                    store_word = s_q.pend;
                    s_d.hold   = 1'b0;
                    if (s_d.stop) s_d.busy = 1'b0;
                end
            end else if (rise) begin
                if (s_q.bit_cnt == last_bit) begin
                    s_d.bit_cnt = '0;
                    if (s_q.full && !rd_en) begin
                        if (ext_sel) begin
                            s_d.busy = 1'b0;
                            s_d.stop = 1'b0;
                        end else begin
                            s_d.hold = 1'b1;
                            s_d.pend = word_now;
                        end
                    end else begin
                        store_req = 1'b1;
                        if (s_d.stop) s_d.busy = 1'b0;
                    end
                end else begin
                    s_d.shreg   = {s_q.shreg[WORD_W-2:0], ser_in};
                    s_d.bit_cnt = s_q.bit_cnt + BIT_W'(1);
                end
            end
        end

        if (store_req) begin
            if (s_q.wr_idx == s_q.cnt) begin
                s_d.full   = 1'b1;
                s_d.irq    = 1'b1;
                s_d.wr_idx = '0;
            end else begin
                s_d.wr_idx = s_q.wr_idx + AW'(1);
            end
        end

        if (word8 != s_q.mode8) begin
            s_d.mode8   = word8;
            buf_clr     = 1'b1;
            s_d.wr_idx  = '0;
            s_d.full    = 1'b0;
            s_d.bit_cnt = '0;
        end

        if (inhibit) begin
            s_d.busy    = 1'b0;
            s_d.stop    = 1'b0;
            s_d.hold    = 1'b0;
            s_d.bit_cnt = '0;
        end

        if (cnt_wr && (!s_q.busy || (s_q.hold && !ext_sel))) s_d.cnt = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bsrx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (store_req),
        .widx  (s_q.wr_idx),
        .wdata (store_word),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    assign rd_data = rd_word;
    assign busy    = s_q.busy;
    assign irq     = s_q.irq;

    // R3: the interrupt lasts a single cycle
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: inhibit ends reception at the next edge
    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !busy);
    // R11: a start edge while idle raises busy
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && !s_q.start_q && !busy && !inhibit) |=> busy);
    // R4: a wait only exists inside a session and keeps the clock low
    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> busy);
    p_hold_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold && !rd_en && !inhibit) |=> !sck_out);
endmodule

// File: tb/bsync_rx_bench.sv
`timescale 1ns/1ps
module bsync_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_en = 0, inhibit = 0, word8 = 0, ext_sel = 0;
    logic       ext_sck = 0, ser_in = 0, cnt_wr = 0, rd_en = 0;
    logic [2:0] cnt_val = 0, rd_addr = 0;
    logic [7:0] rd_data;
    logic       sck_out, busy, irq;

    int checks = 0, failures = 0, irq_cnt = 0, irq_wide = 0;
    logic irq_prev = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bsync_rx u_bsync_rx (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .inhibit(inhibit),
        .word8(word8), .ext_sel(ext_sel), .ext_sck(ext_sck), .ser_in(ser_in),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .sck_out(sck_out), .busy(busy), .irq(irq)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (irq && irq_prev) irq_wide++;
        irq_prev = irq;
    end

    // vector: [9]=word8, [8]=ext_sel, [7:0]=data
    localparam logic [9:0] VECS [6] = '{
        {1'b0, 1'b0, 8'h0B}, {1'b1, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h06},
        {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'hF9}, {1'b1, 1'b0, 8'h81}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic cpu_read(input logic [2:0] a);
        @(negedge clk); rd_addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic set_cnt(input logic [2:0] v);
        @(negedge clk); cnt_val = v; cnt_wr = 1;
        @(negedge clk); cnt_wr = 0;
    endtask

    task automatic pulse_inhibit();
        @(negedge clk); inhibit = 1;
        @(negedge clk); inhibit = 0;
    endtask

    // bits sent MSB first from bits[n-1]; each new bit after a falling sck_out
    task automatic int_stream(input logic [31:0] bits, input int n, input bit fresh);
        for (int i = n - 1; i >= 0; i--) begin
            if (!(fresh && i == n - 1)) begin
                @(negedge sck_out);
                #1;
            end
            ser_in = bits[i];
        end
    endtask

    task automatic ext_send(input logic [7:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_in = bits[i]; ext_sck = 0;
            cycles(3);
            ext_sck = 1;
            cycles(5);
        end
        @(negedge clk); ext_sck = 0;
        cycles(5);
    endtask

    task automatic begin_session();
        @(negedge clk); start_en = 0;
        @(negedge clk); start_en = 1;
    endtask

    task automatic end_session();
        pulse_inhibit();
        @(negedge clk); start_en = 0;
        cycles(2);
    endtask

    initial begin
        logic [7:0] v;
        int base, hi;
        cycles(3);
        rst_n = 1;
        cycles(2);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset irq", irq, 0);
        chk("R11 reset sck_out", sck_out, 0);
        peek(3'd4, v); chk("R11 reset slot4", v, 0);

        // table: one single-word session per vector
        foreach (VECS[k]) begin
            logic [7:0] d, e;
            @(negedge clk); word8 = VECS[k][9]; ext_sel = VECS[k][8];
            d = VECS[k][7:0];
            e = VECS[k][9] ? d : {4'b0, d[3:0]};
            cycles(2);
            set_cnt(3'd0);
            base = irq_cnt;
            if (!VECS[k][8]) begin
                begin_session();
                int_stream({24'b0, d}, VECS[k][9] ? 8 : 4, 1'b1);
                cycles(6);
            end else begin
                begin_session();
                ext_send(d, VECS[k][9] ? 8 : 4);
            end
            chk("R3 table irq", irq_cnt, base + 1);
            peek(3'd0, v); chk("R1 table word", v, e);
            end_session();
        end

        // R2/R3/R4/R10: three-word buffer on internal clock, fourth word waits
        @(negedge clk); word8 = 1; ext_sel = 0;
        cycles(2);
        set_cnt(3'd2);
        base = irq_cnt;
        begin_session();
        int_stream(32'hC3_5A_17_E8, 32, 1'b1);
        cycles(10);
        chk("R3 one irq for three words", irq_cnt, base + 1);
        peek(3'd0, v); chk("R2 slot0", v, 8'hC3);
        peek(3'd1, v); chk("R2 slot1", v, 8'h5A);
        peek(3'd2, v); chk("R2 slot2", v, 8'h17);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_out) hi++;
        end
        chk("R4 sck stalled", hi, 0);
        chk("R4 busy during wait", busy, 1);
        set_cnt(3'd0);
        cpu_read(3'd5);
        cycles(4);
        peek(3'd0, v); chk("R4 held word to slot0", v, 8'hE8);
        chk("R10 count rewritten during wait", irq_cnt, base + 2);
        end_session();

        // R5: read between interrupt and next word, no wait
        @(negedge clk); word8 = 0;
        cycles(2);
        set_cnt(3'd0);
        base = irq_cnt;
        begin_session();
        fork
            int_stream(32'h0000_006D, 8, 1'b1);
            begin
                @(posedge irq);
                cpu_read(3'd0);
            end
        join
        cycles(6);
        chk("R5 second irq", irq_cnt, base + 2);
        peek(3'd0, v); chk("R5 second word stored", v, 8'h0D);
        end_session();

        // R6: external overrun cancels reception
        @(negedge clk); ext_sel = 1;
        cycles(2);
        base = irq_cnt;
        begin_session();
        ext_send(8'h09, 4);
        chk("R6 first irq", irq_cnt, base + 1);
        ext_send(8'h04, 4);
        cycles(2);
        chk("R6 busy dropped", busy, 0);
        peek(3'd0, v); chk("R6 slot0 kept", v, 8'h09);
        ext_send(8'h0E, 4);
        chk("R6 no later irq", irq_cnt, base + 1);
        peek(3'd0, v); chk("R6 slot0 unchanged", v, 8'h09);
        @(negedge clk); start_en = 0;

        // R10: count write ignored while busy on external clock
        set_cnt(3'd1);
        base = irq_cnt;
        begin_session();
        set_cnt(3'd0);
        ext_send(8'h03, 4);
        chk("R10 busy write ignored", irq_cnt, base);
        end_session();
        set_cnt(3'd0);
        begin_session();
        ext_send(8'h0A, 4);
        chk("R10 idle write accepted", irq_cnt, base + 1);
        end_session();

        // R7/R11: graceful stop
        @(negedge clk); word8 = 1; ext_sel = 0;
        cycles(2);
        set_cnt(3'd7);
        @(negedge clk); start_en = 0;
        @(negedge clk); start_en = 1;
        #1 chk("R11 busy not yet", busy, 0);
        fork
            int_stream(32'h0000_00B6, 8, 1'b1);
            begin
                @(negedge clk);
                chk("R11 busy after start edge", busy, 1);
                repeat (3) @(negedge sck_out);
                @(negedge clk); start_en = 0;
                @(negedge clk);
                chk("R7 busy held mid-word", busy, 1);
            end
        join
        cycles(6);
        chk("R7 busy dropped", busy, 0);
        peek(3'd0, v); chk("R7 final word stored", v, 8'hB6);

        // R8: inhibit discards the partial word
        base = irq_cnt;
        begin_session();
        int_stream(32'h0000_001F, 5, 1'b1);
        @(negedge clk); inhibit = 1;
        @(negedge clk); inhibit = 0;
        chk("R8 busy low", busy, 0);
        cycles(20);
        peek(3'd0, v); chk("R8 slot0 unchanged", v, 8'hB6);
        peek(3'd1, v); chk("R8 slot1 untouched", v, 8'h00);
        chk("R8 no irq", irq_cnt, base);
        @(negedge clk); start_en = 0;

        // R9: mode change clears buffer
        @(negedge clk); word8 = 0;
        cycles(2);
        peek(3'd0, v); chk("R9 slot0 cleared", v, 0);

        chk("R3 irq single cycle", irq_wide, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule